// File: doc/BRIEF.md
# Glitch-Free Dual Reference Clock Switchover

The block picks one of two reference clocks and passes it to a single output clock. Clock 0 drives the output after reset. A swap starts on a rising edge of the switch request, and the request must stay high long enough. Each swap toggles the selection once. When automatic mode is enabled, the block also swaps when the selected clock stops toggling and the other clock is still running.

Each input clock has an activity monitor. The monitor runs in the other clock's domain and raises a bad flag for its clock when the clock goes quiet. The selection is split across the two clock domains. Each domain holds one toggle bit, and the selection is the XOR of the two bits. Each domain also holds its own enable for the output gate. The outgoing clock is gated off on its own falling edge. Only after that is the incoming clock gated on, on its own falling edge. A swap towards a clock that is not running waits until that clock runs again.

The reset input is synchronous. Both clocks must run while reset is high.

Top module: `clksw_top`

## Requirements
- R1: After reset, clock 0 is selected: `active_o` is 0, `bad0_o` and `bad1_o` are 0, and `clk_o` follows `clk0_i`.
- R2: A rising edge of `switch_req_i` starts a swap when the request then stays high for at least HOLD (3) cycles of each input clock. The selection then toggles, `active_o` changes to the new index, and `clk_o` follows the new clock.
- R3: A request pulse that is shorter than HOLD cycles of the slower input clock leaves the selection unchanged.
- R4: Holding the request high after a swap causes no further swap, and its falling edge never swaps back.
- R5: A new low-then-high qualified pulse toggles the selection again, so a second pulse returns to clock 0.
- R6: While the target clock is stopped, a qualified request does not change the selection. The swap completes once the target clock runs again, provided the request is still high at that point.
- R7: During a manual swap with both clocks running, neither bad flag rises.
- R8: A clock's bad flag (`bad0_o` for clock 0, `bad1_o` for clock 1) sets when the other clock's domain sees no edge of that clock for WINDOW (8) consecutive cycles, after a two-flop synchronizer. The flag clears after RECOVER (4) edges are seen again.
- R9: With `auto_en_i` at 1, a bad selected clock with a good partner causes a swap to the partner without any request. With `auto_en_i` at 0, no such swap happens.
- R10: The output never carries a high or low pulse shorter than the shorter half period of the two inputs, and at most one clock gate is open at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Reference clock 0, selected after reset |
| clk1_i | input | 1 | Reference clock 1 |
| rst_i | input | 1 | Synchronous active-high reset, held while both clocks run |
| switch_req_i | input | 1 | Manual swap request, asynchronous to both clocks |
| auto_en_i | input | 1 | 1 enables the swap away from a dead selected clock |
| clk_o | output | 1 | Muxed output clock |
| active_o | output | 1 | Index of the selected clock (0 or 1) |
| bad0_o | output | 1 | Clock 0 is considered stopped |
| bad1_o | output | 1 | Clock 1 is considered stopped |

## Verification
The bench runs clock 0 at 10 ns and clock 1 at 14 ns. A 25 ns request pulse therefore qualifies only in the faster domain. A design that counted hold time in only one domain would swap on that pulse.

The bench stops clock 1 before issuing a qualified request. A controller that did not wait for the target clock would switch the output onto a dead clock. A controller that dropped the pending request would never complete the swap once clock 1 ran again.

The bench also holds the request high and then releases it. This exposes logic that acts on levels or on falling edges, because such logic would swap again.

Throughout the run, the bench measures every high and low phase of `clk_o` to catch runt pulses from a bad gate handover. It also samples the width of the output high phase to confirm which clock is really being driven.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  // Per-domain state that the partner domain samples through its synchronizer
  typedef struct packed {
    logic tog;    // toggles on every edge of the lane clock (activity beacon)
    logic sel_t;  // this lane's share of the selection (sel = xor of both)
    logic qual;   // request qualified in this lane's domain
    logic en;     // this lane's output gate enable
  } lane_xing_t;
endpackage

// File: rtl/clksw_req_qual.sv
`timescale 1ns/1ps
module clksw_req_qual #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic lvl,
  output logic qual
);
  localparam int CW = $clog2(HOLD + 1);

  logic r1, r2, r3, arm, rise;
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= 1'b0;
      r2 <= 1'b0;
      r3 <= 1'b0;
    end else begin
      r1 <= req;
      r2 <= r1;
      r3 <= r2;
    end
  end

  assign rise = r2 & ~r3;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm  <= 1'b0;
      hcnt <= '0;
    end else if (!r2) begin
      arm  <= 1'b0;
      hcnt <= '0;
    end else if (rise) begin
      arm  <= 1'b1;
      hcnt <= CW'(1);
    end else if (arm && hcnt != CW'(HOLD)) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign lvl  = r2;
  assign qual = arm & r2 & (hcnt == CW'(HOLD));

  // R3: qualification only after the synchronized request has been high for consecutive cycles
  a_r3_hold_before_qualify: assert property (@(posedge clk) disable iff (rst)
    $rose(qual) |-> ($past(lvl) && $past(lvl, 2)));
endmodule

// File: rtl/clksw_activity_mon.sv
`timescale 1ns/1ps
module clksw_activity_mon #(
  parameter int WINDOW  = 8,
  parameter int RECOVER = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  output logic bad
);
  localparam int MAXC = (WINDOW > RECOVER) ? WINDOW : RECOVER;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (!bad) begin
      if (edge_seen) begin
        cnt <= '0;
      end else if (cnt == CW'(WINDOW - 1)) begin
        cnt <= '0;
        bad <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (edge_seen) begin
      if (cnt == CW'(RECOVER - 1)) begin
        cnt <= '0;
        bad <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: the flag only rises after a quiet cycle and only falls after an observed edge
  a_r8_set_after_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(bad) |-> !$past(edge_seen));
  a_r8_clear_after_edges: assert property (@(posedge clk) disable iff (rst)
    $fell(bad) |-> $past(edge_seen));
endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
module clksw_lane
  import clksw_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int HOLD    = 3,
  parameter int WINDOW  = 8,
  parameter int RECOVER = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       auto_en,
  input  logic       kill,        // this lane's own clock is flagged bad
  input  lane_xing_t peer_i,
  output lane_xing_t own_o,
  output logic       peer_bad_o   // the partner clock is flagged bad
);
  localparam logic ME = (IDX != 0);

  lane_xing_t s1, s2;
  logic tog_d, peer_t_d;
  logic peer_edge, lvl, qual;
  logic sel_t, done, tog, en_q1, en;
  logic owner, settled, both, fire, auto_go, want;

  // two-flop synchronizer for everything the partner domain publishes
  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= '0;
      s2       <= '0;
      tog_d    <= 1'b0;
      peer_t_d <= 1'b0;
    end else begin
      s1       <= peer_i;
      s2       <= s1;
      tog_d    <= s2.tog;
      peer_t_d <= s2.sel_t;
    end
  end

  assign peer_edge = s2.tog ^ tog_d;

  clksw_activity_mon #(.WINDOW(WINDOW), .RECOVER(RECOVER)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .edge_seen (peer_edge),
    .bad       (peer_bad_o)
  );

  clksw_req_qual #(.HOLD(HOLD)) u_qual (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .lvl  (lvl),
    .qual (qual)
  );

  assign owner   = ((sel_t ^ s2.sel_t) == ME);
  assign settled = (s2.sel_t == peer_t_d);
  assign both    = qual & s2.qual;
  assign fire    = both & ~done & owner & settled;
  assign auto_go = auto_en & peer_bad_o & ~owner;
  assign want    = owner & ~s2.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog   <= 1'b0;
      sel_t <= 1'b0;
      done  <= 1'b0;
    end else begin
      tog <= ~tog;
      if (fire || auto_go) sel_t <= ~sel_t;
      if (!lvl)      done <= 1'b0;
      else if (both) done <= 1'b1;
    end
  end

  // gate enable: sync on the rising edge, applied on the falling edge
  always_ff @(posedge clk or posedge kill) begin
    if (kill)     en_q1 <= 1'b0;
    else if (rst) en_q1 <= (IDX == 0);
    else          en_q1 <= want;
  end

  always_ff @(negedge clk or posedge kill) begin
    if (kill)     en <= 1'b0;
    else if (rst) en <= (IDX == 0);
    else          en <= en_q1;
  end

  assign own_o.tog   = tog;
  assign own_o.sel_t = sel_t;
  assign own_o.qual  = qual;
  assign own_o.en    = en;

  // R4: a selection change always has a qualified request or a bad partner behind it
  a_r4_swap_has_cause: assert property (@(posedge clk) disable iff (rst)
    (sel_t != $past(sel_t)) |-> ($past(qual) || $past(peer_bad_o)));
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int HOLD    = 3,
  parameter int WINDOW  = 8,
  parameter int RECOVER = 4
) (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic rst_i,
  input  logic switch_req_i,
  input  logic auto_en_i,
  output logic clk_o,
  output logic active_o,
  output logic bad0_o,
  output logic bad1_o
);
  logic [1:0] clk_v;
  logic [1:0] peer_bad;
  lane_xing_t xing [2];

  assign clk_v = {clk1_i, clk0_i};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    clksw_lane #(
      .IDX(g), .HOLD(HOLD), .WINDOW(WINDOW), .RECOVER(RECOVER)
    ) u_lane (
      .clk        (clk_v[g]),
      .rst        (rst_i),
      .req        (switch_req_i),
      .auto_en    (auto_en_i),
      .kill       (peer_bad[1-g]),
      .peer_i     (xing[1-g]),
      .own_o      (xing[g]),
      .peer_bad_o (peer_bad[g])
    );
  end

  assign clk_o    = (clk0_i & xing[0].en) | (clk1_i & xing[1].en);
  assign active_o = xing[0].sel_t ^ xing[1].sel_t;
  assign bad0_o   = peer_bad[1];
  assign bad1_o   = peer_bad[0];

  // R10: the two gates are never open together
  a_r10_single_gate_c0: assert property (@(posedge clk0_i) disable iff (rst_i)
    $onehot0({xing[0].en, xing[1].en}));
  a_r10_single_gate_c1: assert property (@(posedge clk1_i) disable iff (rst_i)
    $onehot0({xing[0].en, xing[1].en}));
endmodule

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
  logic clk0 = 1'b0, clk1 = 1'b0;
  bit   run0 = 1'b1, run1 = 1'b1;
  logic rst = 1'b1, req = 1'b0, auto_en = 1'b0;
  logic clk_o, active, bad0, bad1;

  int vectors = 0, fails = 0, runts = 0, bad0_rises = 0, bad1_rises = 0;
  bit meas = 1'b0, finished = 1'b0;
  real t_r = 0.0, t_f = 0.0, last_hi = 0.0;

  // clock 0 at 100 MHz, clock 1 at 14 ns; a stopped clock finishes its high phase first
  always #5 if (run0 || clk0) clk0 = ~clk0;
  always #7 if (run1 || clk1) clk1 = ~clk1;

  clksw_top dut_i (
    .clk0_i(clk0), .clk1_i(clk1), .rst_i(rst), .switch_req_i(req),
    .auto_en_i(auto_en), .clk_o(clk_o), .active_o(active),
    .bad0_o(bad0), .bad1_o(bad1)
  );

  always @(posedge clk_o) begin
    if (meas && ($realtime - t_f) < 4.5) runts++;
    t_r = $realtime;
  end
  always @(negedge clk_o) begin
    if (meas && ($realtime - t_r) < 4.5) runts++;
    last_hi = $realtime - t_r;
    t_f = $realtime;
  end
  always @(posedge bad0) if (meas) bad0_rises++;
  always @(posedge bad1) if (meas) bad1_rises++;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hi_x10();
    return $rtoi(last_hi * 10.0 + 0.5);
  endfunction

  task automatic t_reset();
    check("R1 active after reset", int'(active), 0);
    check("R1 bad0 after reset", int'(bad0), 0);
    check("R1 bad1 after reset", int'(bad1), 0);
    #100;
    check("R1 clk_o high width x10", hi_x10(), 50);
  endtask

  task automatic t_short_pulse();
    req = 1'b1; #25; req = 1'b0;
    #400;
    check("R3 short pulse keeps clock 0", int'(active), 0);
  endtask

  task automatic t_manual_hold_release();
    int b0, b1;
    b0 = bad0_rises; b1 = bad1_rises;
    req = 1'b1; #600;
    check("R2 swapped to clock 1", int'(active), 1);
    check("R2 clk_o high width x10", hi_x10(), 70);
    #400;
    check("R4 held request no re-swap", int'(active), 1);
    req = 1'b0; #400;
    check("R4 falling edge no swap back", int'(active), 1);
    check("R7 bad0 quiet on manual swap", bad0_rises - b0, 0);
    check("R7 bad1 quiet on manual swap", bad1_rises - b1, 0);
  endtask

  task automatic t_swap_back();
    int b0, b1;
    b0 = bad0_rises; b1 = bad1_rises;
    req = 1'b1; #150; req = 1'b0;
    #500;
    check("R5 second pulse returns to clock 0", int'(active), 0);
    check("R5 clk_o high width x10", hi_x10(), 50);
    check("R7 no bad flag on swap back", (bad0_rises - b0) + (bad1_rises - b1), 0);
  endtask

  task automatic t_dead_target();
    run1 = 1'b0; #60;
    check("R8 bad1 still low inside window", int'(bad1), 0);
    #400;
    check("R8 bad1 set after quiet window", int'(bad1), 1);
    req = 1'b1; #500;
    check("R6 swap waits for stopped target", int'(active), 0);
    run1 = 1'b1; #800;
    check("R6 swap completes when target returns", int'(active), 1);
    check("R8 bad1 cleared after edges", int'(bad1), 0);
    check("R6 clk_o high width x10", hi_x10(), 70);
    req = 1'b0; #300;
  endtask

  task automatic t_auto_swap();
    auto_en = 1'b1;
    run1 = 1'b0; #600;
    check("R9 auto swap away from dead clock 1", int'(active), 0);
    check("R9 clk_o high width x10", hi_x10(), 50);
    run1 = 1'b1; #400;
    check("R8 bad1 cleared after restart", int'(bad1), 0);
    check("R9 no bounce back after recovery", int'(active), 0);
  endtask

  task automatic t_no_auto();
    auto_en = 1'b0;
    run0 = 1'b0; #600;
    check("R9 no swap with auto disabled", int'(active), 0);
    check("R8 bad0 set while clock 0 stopped", int'(bad0), 1);
    run0 = 1'b1; #600;
    check("R8 bad0 cleared after restart", int'(bad0), 0);
    check("R9 clk_o resumes clock 0 width x10", hi_x10(), 50);
  endtask

  task automatic t_glitch();
    check("R10 runt pulses on clk_o", runts, 0);
  endtask

  initial begin
    #203 rst = 1'b0;
    #300 meas = 1'b1;
    t_reset();
    t_short_pulse();
    t_manual_hold_release();
    t_swap_back();
    t_dead_target();
    t_auto_swap();
    t_no_auto();
    t_glitch();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule